// File: doc/BRIEF.md
# Smart card sniffing receiver

A passive, receive-only capture unit for a tap on a card interface. It watches the card reset, card clock and single data line. It never drives any of them. The block recovers each asynchronous character that passes in either direction. Bit timing is measured by counting rising edges of the card clock, not system clocks, so capture follows the card clock frequency whatever it is. The number of card clocks per elementary time unit (etu) comes from a mode register that can be switched at run time among five settings.

All three card lines first go through a two-flop synchroniser clocked by the system clock. A falling edge on the synchronised data line, seen while the receiver is idle and the card is out of reset, starts a character. The state machine has six states: `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_PARITY`, `ST_GUARD` and `ST_RECOVER`. Its transitions are:
- `ST_IDLE` to `ST_START` on a falling edge of the data line.
- `ST_START` to `ST_IDLE` on a glitch, or to `ST_DATA` on a confirmed start bit.
- `ST_DATA` loops eight times and then goes to `ST_PARITY`.
- `ST_PARITY` to `ST_GUARD`.
- `ST_GUARD` to `ST_IDLE` when the line is high, or to `ST_RECOVER` when the line is held low.
- `ST_RECOVER` to `ST_IDLE` once the line is high again.
- Any state to `ST_IDLE` while the card reset is low.

Each captured character produces a one-cycle strobe. The strobe carries the byte, a parity verdict, an error-signal flag and the mode the character was timed in.

Top module: `sc_sniff_rx`

## Requirements
- R1: A character starts only on a high-to-low transition of the synchronised data line while idle. The line is sampled again half an etu later. If it is high at that point, no character is reported and the receiver returns to idle.
- R2: The eight data bits are sampled at 1.5, 2.5 … 8.5 etu after the start edge. The first bit received is placed in bit 0 of `char_data_o`.
- R3: The parity bit is sampled at 9.5 etu. `char_par_ok_o` is 1 exactly when the eight data bits and the parity bit together contain an even number of ones.
- R4: The line is sampled again at 11 etu, inside the guard time. `char_errsig_o` is 1 when the line is low at that point, which is the error signal of the receiving side.
- R5: After a character with the error signal, the receiver waits for the line to return high before it arms for a new start. The low error pulse therefore yields no extra character.
- R6: Mode codes on `mode_sel_i` select card clocks per etu: 0 gives 372, 1 gives 64, 2 gives 32, 3 gives 16 and 4 gives 8. Characters are captured correctly in each mode, and `char_mode_o` reports the code the character was timed with.
- R7: A request with a code of 5, 6 or 7 is ignored, and the current mode is kept.
- R8: A mode request made while a character is in progress does not affect that character. It takes effect once the receiver is back in idle.
- R9: While the synchronised card reset is low, nothing is captured and mode requests are dropped. On release, the mode is 372 clocks per etu (code 0).
- R10: Each character gives exactly one strobe on `char_valid_o`, lasting one system clock cycle.
- R11: After system reset, `char_valid_o` is 0 and `char_mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| card_rst_i | input | 1 | Raw card reset line |
| card_clk_i | input | 1 | Raw card clock line |
| card_io_i | input | 1 | Raw card data line |
| mode_set_i | input | 1 | One-cycle request to change the etu mode |
| mode_sel_i | input | 3 | Requested mode code (see R6) |
| char_valid_o | output | 1 | One-cycle strobe for a captured character |
| char_data_o | output | 8 | Captured byte |
| char_par_ok_o | output | 1 | Even parity held |
| char_errsig_o | output | 1 | Error signal seen in the guard time |
| char_mode_o | output | 3 | Mode code used for this character |

## Verification
The assertions assume that the card clock runs at no more than half the system clock rate, so every card clock edge survives synchronisation and is counted once. They also assume that the data line changes away from card clock rising edges. The stimulus produces the card clock by toggling it every two system cycles. It drives every data-line change on a falling card-clock edge, so each sampling point falls mid-bit. Mode requests are one-cycle pulses issued on the system clock's falling edge. Only legal codes are used, except in the check that illegal codes are ignored.

// File: rtl/sc_sniff_pkg.sv
package sc_sniff_pkg;

    localparam int DATA_BITS = 8;
    localparam int ETU_BASE  = 372;
    localparam int ETU_FAST  = 64;
    localparam int CNT_W     = $clog2(ETU_BASE + ETU_BASE / 2 + 1);
    localparam int IDX_W     = $clog2(DATA_BITS);

    typedef enum logic [2:0] {
        ETU_372 = 3'd0,
        ETU_64  = 3'd1,
        ETU_32  = 3'd2,
        ETU_16  = 3'd3,
        ETU_8   = 3'd4
    } etu_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GUARD,
        ST_RECOVER
    } rx_state_e;

    function automatic logic [CNT_W-1:0] etu_clocks(etu_mode_e m);
        logic [CNT_W-1:0] r;
        unique case (m)
            ETU_372: r = CNT_W'(ETU_BASE);
            ETU_64:  r = CNT_W'(ETU_FAST);
            ETU_32:  r = CNT_W'(ETU_FAST >> 1);
            ETU_16:  r = CNT_W'(ETU_FAST >> 2);
            default: r = CNT_W'(ETU_FAST >> 3);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES+1];

    assign chain[0] = d_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g+1] <= '0;
            else        chain[g+1] <= chain[g];
        end
    end

    assign q_o = chain[STAGES];
endmodule

// File: rtl/sc_etu_mode.sv
module sc_etu_mode
    import sc_sniff_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      card_rst_s,
    input  logic      rx_idle,
    input  logic      set_i,
    input  logic [2:0] sel_i,
    output etu_mode_e mode_o
);
    etu_mode_e mode_q, pend_q;
    logic      pend_v_q;
    logic      legal;

    assign legal  = (sel_i <= 3'(ETU_8));
    assign mode_o = mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= ETU_372;
            pend_q   <= ETU_372;
            pend_v_q <= 1'b0;
        end else if (!card_rst_s) begin
            mode_q   <= ETU_372;
            pend_v_q <= 1'b0;
        end else begin
            if (rx_idle && pend_v_q) begin
                mode_q   <= pend_q;
                pend_v_q <= 1'b0;
            end
            if (set_i && legal) begin
                pend_q   <= etu_mode_e'(sel_i);
                pend_v_q <= 1'b1;
            end
        end
    end

    // R6: the mode register only ever holds a defined code
    p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q <= ETU_8);

    // R9: leaving card reset always finds the base mode
    p_base_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_s) |-> mode_q == ETU_372);
endmodule

// File: rtl/sc_sniff_rx.sv
module sc_sniff_rx
    import sc_sniff_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 card_rst_i,
    input  logic                 card_clk_i,
    input  logic                 card_io_i,
    input  logic                 mode_set_i,
    input  logic [2:0]           mode_sel_i,
    output logic                 char_valid_o,
    output logic [DATA_BITS-1:0] char_data_o,
    output logic                 char_par_ok_o,
    output logic                 char_errsig_o,
    output logic [2:0]           char_mode_o
);
    logic [2:0] sync_q;
    logic       rst_s, clk_s, io_s;

    sc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({card_rst_i, card_clk_i, card_io_i}),
        .q_o   (sync_q)
    );
    assign {rst_s, clk_s, io_s} = sync_q;

    rx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic [IDX_W-1:0]     idx_q, idx_d;
    logic [DATA_BITS-1:0] shift_q, shift_d;
    logic                 par_q, par_d;
    logic                 io_prev_q, clk_prev_q;
    logic                 fall, clk_rise, timing, tick, emit;
    logic [CNT_W-1:0]     etu, half;
    etu_mode_e            mode_q;

    assign fall     = io_prev_q & ~io_s;
    assign clk_rise = clk_s & ~clk_prev_q;
    assign timing   = (state_q != ST_IDLE) && (state_q != ST_RECOVER);
    assign tick     = timing && clk_rise && (cnt_q == CNT_W'(1));
    assign etu      = etu_clocks(mode_q);
    assign half     = etu >> 1;

    sc_etu_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .card_rst_s (rst_s),
        .rx_idle    ((state_q == ST_IDLE) && !fall),
        .set_i      (mode_set_i),
        .sel_i      (mode_sel_i),
        .mode_o     (mode_q)
    );

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        shift_d = shift_q;
        par_d   = par_q;
        emit    = 1'b0;
        if (timing && clk_rise) cnt_d = cnt_q - CNT_W'(1);
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (fall) begin
                    state_d = ST_START;
                    cnt_d   = half;
                end
            end
            ST_START: if (tick) begin
                if (io_s) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_DATA;
                    cnt_d   = etu;
                    idx_d   = '0;
                end
            end
            ST_DATA: if (tick) begin
                shift_d = {io_s, shift_q[DATA_BITS-1:1]};
                cnt_d   = etu;
                if (idx_q == IDX_W'(DATA_BITS - 1)) state_d = ST_PARITY;
                else                                idx_d   = idx_q + IDX_W'(1);
            end
            ST_PARITY: if (tick) begin
                par_d   = io_s;
                cnt_d   = etu + half;
                state_d = ST_GUARD;
            end
            ST_GUARD: if (tick) begin
                emit    = rst_s;
                state_d = io_s ? ST_IDLE : ST_RECOVER;
            end
            ST_RECOVER: if (io_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (!rst_s) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            idx_q      <= '0;
            shift_q    <= '0;
            par_q      <= 1'b0;
            io_prev_q  <= 1'b0;
            clk_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            idx_q      <= idx_d;
            shift_q    <= shift_d;
            par_q      <= par_d;
            io_prev_q  <= io_s;
            clk_prev_q <= clk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_valid_o  <= 1'b0;
            char_data_o   <= '0;
            char_par_ok_o <= 1'b0;
            char_errsig_o <= 1'b0;
            char_mode_o   <= '0;
        end else begin
            char_valid_o <= emit;
            if (emit) begin
                char_data_o   <= shift_q;
                char_par_ok_o <= ~(^{shift_q, par_q});
                char_errsig_o <= ~io_s;
                char_mode_o   <= 3'(mode_q);
            end
        end
    end

    // R10: a strobe never lasts beyond one cycle
    p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid_o |=> !char_valid_o);

    // R9: card reset keeps the receiver idle and silent
    p_quiet_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_s |=> (state_q == ST_IDLE) && !char_valid_o);

    // R8: the mode cannot move under a character in flight
    p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && rst_s) |=> $stable(mode_q));

    // R6: the etu counter stays within the longest interval of the active mode
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= etu + half);
endmodule

// File: tb/sc_sniff_rx_tb.sv
module sc_sniff_rx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_rst_i = 1'b0;
    logic       sim_clk = 1'b0;
    logic       card_io_i = 1'b1;
    logic       mode_set_i = 1'b0;
    logic [2:0] mode_sel_i = 3'd0;
    logic       char_valid_o;
    logic [7:0] char_data_o;
    logic       char_par_ok_o;
    logic       char_errsig_o;
    logic [2:0] char_mode_o;

    int tests = 0;
    int fails = 0;
    int vcount = 0;
    int got_data, got_par, got_err, got_mode;

    sc_sniff_rx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_rst_i    (card_rst_i),
        .card_clk_i    (sim_clk),
        .card_io_i     (card_io_i),
        .mode_set_i    (mode_set_i),
        .mode_sel_i    (mode_sel_i),
        .char_valid_o  (char_valid_o),
        .char_data_o   (char_data_o),
        .char_par_ok_o (char_par_ok_o),
        .char_errsig_o (char_errsig_o),
        .char_mode_o   (char_mode_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial forever begin
        repeat (2) @(negedge clk);
        sim_clk = ~sim_clk;
    end

    always @(negedge clk) begin
        if (char_valid_o) begin
            vcount   = vcount + 1;
            got_data = int'(char_data_o);
            got_par  = int'(char_par_ok_o);
            got_err  = int'(char_errsig_o);
            got_mode = int'(char_mode_o);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int etu_of(input int code);
        return (code == 0) ? 372 : (64 >> (code - 1));
    endfunction

    task automatic set_mode(input int code);
        @(negedge clk);
        mode_set_i = 1'b1;
        mode_sel_i = 3'(code);
        @(negedge clk);
        mode_set_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par,
                              input bit errsig, input int etu);
        logic p;
        p = (^d) ^ bad_par;
        @(negedge sim_clk);
        card_io_i = 1'b0;
        repeat (etu) @(negedge sim_clk);
        for (int i = 0; i < 8; i++) begin
            card_io_i = d[i];
            repeat (etu) @(negedge sim_clk);
        end
        card_io_i = p;
        repeat (etu) @(negedge sim_clk);
        card_io_i = 1'b1;
        repeat (etu / 2) @(negedge sim_clk);
        if (errsig) begin
            card_io_i = 1'b0;
            repeat (etu + etu / 2) @(negedge sim_clk);
            card_io_i = 1'b1;
        end
        repeat (2 * etu) @(negedge sim_clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_char(input int n0, input int d, input int par_ok,
                               input int err, input int mode);
        chk("R10 one strobe per character", vcount - n0, 1);
        chk("R2 data byte", got_data, d);
        chk("R3 parity verdict", got_par, par_ok);
        chk("R4 error-signal flag", got_err, err);
        chk("R6 mode tag", got_mode, mode);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R11: reset state
        chk("R11 strobe idle after reset", int'(char_valid_o), 0);
        chk("R11 mode tag after reset", int'(char_mode_o), 0);
        card_rst_i = 1'b1;
        repeat (10) @(negedge clk);

        // R6 / R2 / R3: sweep over every mode
        for (int m = 0; m < 5; m++) begin
            int nb;
            set_mode(m);
            nb = (m == 0) ? 2 : ((m == 4) ? 32 : 4);
            for (int k = 0; k < nb; k++) begin
                logic [7:0] d;
                d = 8'(k * 37 + 5 + m * 91);
                n0 = vcount;
                send_frame(d, 1'b0, 1'b0, etu_of(m));
                expect_char(n0, int'(d), 1, 0, m);
            end
        end

        // R3: deliberately wrong parity, fastest mode
        for (int k = 0; k < 3; k++) begin
            logic [7:0] d;
            d = 8'(k * 85 + 3);
            n0 = vcount;
            send_frame(d, 1'b1, 1'b0, 8);
            expect_char(n0, int'(d), 0, 0, 4);
        end

        // R4 / R5: error signal in the guard time
        n0 = vcount;
        send_frame(8'h6E, 1'b0, 1'b1, 8);
        expect_char(n0, 8'h6E, 1, 1, 4);
        chk("R5 no spurious character after error pulse", vcount - n0, 1);
        n0 = vcount;
        send_frame(8'h17, 1'b0, 1'b0, 8);
        expect_char(n0, 8'h17, 1, 0, 4);

        // R1: short low glitch is rejected
        n0 = vcount;
        @(negedge sim_clk);
        card_io_i = 1'b0;
        @(negedge sim_clk);
        card_io_i = 1'b1;
        repeat (24) @(negedge sim_clk);
        chk("R1 glitch yields no character", vcount - n0, 0);
        n0 = vcount;
        send_frame(8'hD2, 1'b0, 1'b0, 8);
        chk("R1 receiver rearmed after glitch", got_data, 8'hD2);
        expect_char(n0, 8'hD2, 1, 0, 4);

        // R7: illegal code is ignored
        set_mode(6);
        n0 = vcount;
        send_frame(8'h3C, 1'b0, 1'b0, 8);
        chk("R7 illegal code keeps mode", got_mode, 4);
        expect_char(n0, 8'h3C, 1, 0, 4);

        // R8: request during a character is deferred
        set_mode(2);
        n0 = vcount;
        fork
            send_frame(8'hC3, 1'b0, 1'b0, 32);
            begin
                repeat (300) @(negedge clk);
                mode_set_i = 1'b1;
                mode_sel_i = 3'd4;
                @(negedge clk);
                mode_set_i = 1'b0;
            end
        join
        chk("R8 character keeps old mode", got_mode, 2);
        expect_char(n0, 8'hC3, 1, 0, 2);
        n0 = vcount;
        send_frame(8'h99, 1'b0, 1'b0, 8);
        chk("R8 new mode applied after idle", got_mode, 4);
        expect_char(n0, 8'h99, 1, 0, 4);

        // R9: card reset low blocks capture and mode requests
        set_mode(1);
        card_rst_i = 1'b0;
        repeat (10) @(negedge clk);
        n0 = vcount;
        fork
            send_frame(8'h55, 1'b0, 1'b0, 64);
            begin
                repeat (200) @(negedge clk);
                mode_set_i = 1'b1;
                mode_sel_i = 3'd3;
                @(negedge clk);
                mode_set_i = 1'b0;
            end
        join
        chk("R9 nothing captured in card reset", vcount - n0, 0);
        card_rst_i = 1'b1;
        repeat (10) @(negedge clk);
        n0 = vcount;
        send_frame(8'hA7, 1'b0, 1'b0, 372);
        chk("R9 base mode after release", got_mode, 0);
        expect_char(n0, 8'hA7, 1, 0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule